// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Front End

This block is the bus-facing logic of a 32K x 8 serial EEPROM model. It watches the clock and data lines of a two-wire (I2C-style) bus. It finds start and stop conditions and receives the device select byte. For writes it also takes two word-address bytes. It answers each accepted byte with an acknowledge, which it gives by pulling the data line low. Received data bytes go straight to a memory array through a one-cycle write strobe. Read data comes from the same array through a synchronous read strobe, and the block shifts it out most significant bit first.

A persistent 15-bit address counter links one transaction to the next. Writes step it inside a 64-byte page, and reads step it across the whole array. This gives current-address reads, random reads (a dummy write followed by a repeated start) and open-ended sequential reads. When a stop closes a write that carried data, the block sends a pulse to an external write-cycle timer. While that timer reports busy, the block refuses its device select byte, so a master can poll for the end of the write cycle.

Top module: `twi_eeprom_slave`

## Requirements
- R1: After reset the data line is not pulled, no array strobe or cycle pulse is issued, and the block ignores bus traffic until a start condition.
- R2: A select byte whose four high bits are 1010 and whose next three bits equal `sel_pins_i` is acknowledged (line pulled low during the ninth clock). Bit 0 of the select byte is the direction: 1 means read. Any other select byte gets no acknowledge, and the block stays silent until the next start.
- R3: A write select byte is followed by a high and a low address byte. Bit 7 of the high byte is ignored, and the remaining 15 bits give the word address. Each following data byte is acknowledged and written to the array.
- R4: Successive data bytes in one write step only the low 6 address bits. After offset 63 of a page, the next byte goes to offset 0 of the same page.
- R5: A stop that ends a write with at least one data byte gives exactly one single-cycle `cycle_start_o` pulse. A stop that ends a transfer with no data bytes gives none.
- R6: While `wr_busy_i` is high, the select byte is not acknowledged and no array write occurs. Once it drops, the select byte is acknowledged again.
- R7: Between transfers the address counter holds the last accessed address plus one. A read select byte with no preceding address returns the byte at that address.
- R8: A write select byte and two address bytes, then a repeated start and a read select byte, return the byte at the loaded address.
- R9: In a read, each master acknowledge makes the block send the next byte. The address runs across page borders and wraps from 0x7FFF to 0x0000.
- R10: When the master leaves the ninth clock of a read byte high (no acknowledge), the block releases the line and drives nothing more until a start.
- R11: A start or stop that arrives in the middle of a byte abandons that byte. A following select byte is received from its first bit.
- R12: The block changes its pull on the data line only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired value) |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| sel_pins_i | input | 3 | Hardwired device select bits |
| wr_busy_i | input | 1 | Internal write cycle in progress |
| cycle_start_o | output | 1 | One-cycle pulse: begin the internal write cycle |
| mem_addr_o | output | 15 | Array address for the current strobe |
| mem_wr_o | output | 1 | Array write strobe |
| mem_wdata_o | output | 8 | Array write data |
| mem_rd_o | output | 1 | Array read strobe; data is expected one cycle later |
| mem_rdata_i | input | 8 | Array read data |

## Verification
The properties assume that the bus clock is slow next to `clk`. Each bus clock level must last well beyond the three system cycles of synchronizer and edge delay. Otherwise the check that the pull moves only while the clock line is low could see the line already high. They also assume the master changes the data line only while the clock is low, except for the start and stop edges. The bench keeps each bus quarter-period at 8 system clocks. It moves data only in the middle of the clock-low phase, and it holds the clock high for a full quarter on both sides of every start and stop edge.

// File: rtl/twi_eep_pkg.sv
package twi_eep_pkg;

    localparam logic [3:0] DEV_CODE = 4'b1010;
    localparam int SEL_W  = 3;
    localparam int BYTE_W = 8;
    localparam int BITS_PER_BYTE = BYTE_W;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_WDAT,
        PH_RD,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic [3:0]       code;
        logic [SEL_W-1:0] sel;
        logic             rd;
    } devbyte_t;

    function automatic logic dev_hit(devbyte_t b, logic [SEL_W-1:0] pins);
        return (b.code == DEV_CODE) && (b.sel == pins);
    endfunction

    function automatic logic is_rx_phase(phase_e p);
        return (p == PH_DEV) || (p == PH_AHI) || (p == PH_ALO) || (p == PH_WDAT);
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sh;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '1;
            prev <= 1'b1;
        end else begin
            sh   <= {sh[STAGES-2:0], din};
            prev <= sh[STAGES-1];
        end
    end

    assign lvl  = sh[STAGES-1];
    assign rise = sh[STAGES-1] & ~prev;
    assign fall = ~sh[STAGES-1] & prev;
endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect (
    input  logic scl_lvl,
    input  logic scl_rise,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_steady_hi;

    assign scl_steady_hi = scl_lvl & ~scl_rise;
    assign start_det     = scl_steady_hi & sda_fall;
    assign stop_det      = scl_steady_hi & sda_rise;
endmodule

// File: rtl/twi_addr_ctr.sv
module twi_addr_ctr #(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step_page,
    input  logic              step_full,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] page_next;
    logic [ADDR_W-1:0] full_next;

    assign full_next = addr + 1'b1;

    generate
        if (PAGE_W >= ADDR_W) begin : g_flat
            assign page_next = full_next;
        end else begin : g_paged
            logic [PAGE_W-1:0] off_next;
            assign off_next  = addr[PAGE_W-1:0] + 1'b1;
            assign page_next = {addr[ADDR_W-1:PAGE_W], off_next};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)            addr <= '0;
        else if (load)      addr <= load_val;
        else if (step_page) addr <= page_next;
        else if (step_full) addr <= full_next;
    end
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
    import twi_eep_pkg::*;
#(
    parameter int ADDR_W      = 15,
    parameter int PAGE_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic [SEL_W-1:0]  sel_pins_i,
    input  logic              wr_busy_i,
    output logic              cycle_start_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_wr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    output logic              mem_rd_o,
    input  logic [BYTE_W-1:0] mem_rdata_i
);
    localparam int NLINES = 2;
    localparam int CNT_W  = $clog2(BITS_PER_BYTE + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BITS_PER_BYTE);

    // line 0 = clock, line 1 = data
    logic [NLINES-1:0] line_in, line_lvl, line_rise, line_fall;
    assign line_in = {sda_i, scl_i};

    genvar g;
    generate
        for (g = 0; g < NLINES; g++) begin : g_sync
            twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk  (clk),
                .rst  (rst),
                .din  (line_in[g]),
                .lvl  (line_lvl[g]),
                .rise (line_rise[g]),
                .fall (line_fall[g])
            );
        end
    endgenerate

    logic scl_rise, scl_fall, sda_lvl, start_det, stop_det;
    assign scl_rise = line_rise[0];
    assign scl_fall = line_fall[0];
    assign sda_lvl  = line_lvl[1];

    twi_cond_detect u_cond (
        .scl_lvl   (line_lvl[0]),
        .scl_rise  (line_rise[0]),
        .sda_rise  (line_rise[1]),
        .sda_fall  (line_fall[1]),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    phase_e            phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic              in_ack;      // inside the ninth clock
    logic              master_ack;  // ninth clock belongs to the master
    logic [BYTE_W-1:0] rx_sh, tx_sh, addr_hi;
    logic              pull_q, wrote_any, rd_pend, cyc_q;
    logic              wr_q, rd_q;
    logic [ADDR_W-1:0] maddr_q;
    logic [BYTE_W-1:0] wdata_q;

    devbyte_t dev_b;
    assign dev_b = devbyte_t'(rx_sh);

    logic byte_done, dev_ok, quiet;
    assign quiet     = ~start_det & ~stop_det;
    assign byte_done = quiet & scl_fall & ~in_ack & (bit_cnt == LAST_BIT);
    assign dev_ok    = dev_hit(dev_b, sel_pins_i) & ~wr_busy_i;

    // address counter control
    logic [ADDR_W-1:0]      ctr_addr;
    logic                   ctr_load, ctr_page, ctr_full;
    logic [2*BYTE_W-1:0]    addr_join;
    logic                   rd_next;

    assign addr_join = {addr_hi, rx_sh};
    assign rd_next   = quiet & (phase == PH_RD) & scl_rise & in_ack & master_ack & ~sda_lvl;
    assign ctr_load  = byte_done & (phase == PH_ALO);
    assign ctr_page  = byte_done & (phase == PH_WDAT);
    assign ctr_full  = (byte_done & (phase == PH_DEV) & dev_ok & dev_b.rd) | rd_next;

    twi_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .load      (ctr_load),
        .load_val  (addr_join[ADDR_W-1:0]),
        .step_page (ctr_page),
        .step_full (ctr_full),
        .addr      (ctr_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            bit_cnt    <= '0;
            in_ack     <= 1'b0;
            master_ack <= 1'b0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            addr_hi    <= '0;
            pull_q     <= 1'b0;
            wrote_any  <= 1'b0;
            rd_pend    <= 1'b0;
            cyc_q      <= 1'b0;
            wr_q       <= 1'b0;
            rd_q       <= 1'b0;
            maddr_q    <= '0;
            wdata_q    <= '0;
        end else begin
            wr_q    <= 1'b0;
            rd_q    <= 1'b0;
            cyc_q   <= 1'b0;
            rd_pend <= rd_q;
            if (rd_pend) tx_sh <= mem_rdata_i;

            if (start_det) begin
                phase     <= PH_DEV;
                bit_cnt   <= '0;
                in_ack    <= 1'b0;
                pull_q    <= 1'b0;
                wrote_any <= 1'b0;
            end else if (stop_det) begin
                phase     <= PH_IDLE;
                bit_cnt   <= '0;
                in_ack    <= 1'b0;
                pull_q    <= 1'b0;
                cyc_q     <= wrote_any;
                wrote_any <= 1'b0;
            end else if (is_rx_phase(phase)) begin
                if (scl_rise && !in_ack && bit_cnt < LAST_BIT) begin
                    rx_sh   <= {rx_sh[BYTE_W-2:0], sda_lvl};
                    bit_cnt <= bit_cnt + 1'b1;
                end else if (byte_done) begin
                    in_ack     <= 1'b1;
                    master_ack <= 1'b0;
                    pull_q     <= 1'b1;
                    unique case (phase)
                        PH_DEV: begin
                            if (!dev_ok) begin
                                phase  <= PH_IDLE;
                                in_ack <= 1'b0;
                                pull_q <= 1'b0;
                            end else if (dev_b.rd) begin
                                phase   <= PH_RD;
                                rd_q    <= 1'b1;
                                maddr_q <= ctr_addr;
                            end else begin
                                phase <= PH_AHI;
                            end
                        end
                        PH_AHI: begin
                            addr_hi <= rx_sh;
                            phase   <= PH_ALO;
                        end
                        PH_ALO: phase <= PH_WDAT;
                        default: begin
                            wr_q      <= 1'b1;
                            maddr_q   <= ctr_addr;
                            wdata_q   <= rx_sh;
                            wrote_any <= 1'b1;
                        end
                    endcase
                end else if (scl_fall && in_ack) begin
                    in_ack  <= 1'b0;
                    bit_cnt <= '0;
                    pull_q  <= 1'b0;
                end
            end else if (phase == PH_RD) begin
                if (scl_fall && in_ack) begin
                    in_ack  <= 1'b0;
                    bit_cnt <= '0;
                    pull_q  <= ~tx_sh[BYTE_W-1];
                end else if (scl_rise && in_ack && master_ack) begin
                    if (sda_lvl) begin
                        phase <= PH_HOLD;
                    end else begin
                        rd_q    <= 1'b1;
                        maddr_q <= ctr_addr;
                    end
                end else if (scl_rise && !in_ack && bit_cnt < LAST_BIT) begin
                    bit_cnt <= bit_cnt + 1'b1;
                end else if (scl_fall && !in_ack && bit_cnt == LAST_BIT) begin
                    in_ack     <= 1'b1;
                    master_ack <= 1'b1;
                    pull_q     <= 1'b0;
                end else if (scl_fall && !in_ack && bit_cnt != '0) begin
                    tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                    pull_q <= ~tx_sh[BYTE_W-2];
                end
            end
        end
    end

    assign sda_pull_o    = pull_q;
    assign cycle_start_o = cyc_q;
    assign mem_addr_o    = maddr_q;
    assign mem_wr_o      = wr_q;
    assign mem_wdata_o   = wdata_q;
    assign mem_rd_o      = rd_q;
endmodule

// File: rtl/twi_eeprom_slave_chk.sv
module twi_eeprom_slave_chk (
    input logic clk,
    input logic rst,
    input logic scl_i,
    input logic sda_pull_o,
    input logic wr_busy_i,
    input logic cycle_start_o,
    input logic mem_wr_o,
    input logic mem_rd_o
);
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sda_pull_o && !mem_wr_o && !cycle_start_o));

    assert_strobes_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(mem_wr_o && mem_rd_o));

    assert_cycle_single_R5: assert property (@(posedge clk) disable iff (rst)
        cycle_start_o |=> !cycle_start_o);

    assert_no_write_busy_R6: assert property (@(posedge clk) disable iff (rst)
        wr_busy_i |-> !mem_wr_o);

    assert_pull_moves_low_R12: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull_o) |-> !scl_i);
endmodule

bind twi_eeprom_slave twi_eeprom_slave_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .scl_i         (scl_i),
    .sda_pull_o    (sda_pull_o),
    .wr_busy_i     (wr_busy_i),
    .cycle_start_o (cycle_start_o),
    .mem_wr_o      (mem_wr_o),
    .mem_rd_o      (mem_rd_o)
);

// File: tb/twi_eeprom_slave_tb.sv
module twi_eeprom_slave_tb;
    localparam int ADDR_W = 15;
    localparam int Q      = 8;
    localparam int BUSY_CYC = 300;
    localparam logic [2:0] SEL = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, SEL, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, SEL, 1'b1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_pull, cyc_start, mem_wr, mem_rd;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;
    logic wr_busy;
    logic sda_line;
    int busy_cnt = 0;
    int cs_count = 0;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;
    assign wr_busy  = (busy_cnt != 0);

    twi_eeprom_slave u_dut (
        .clk (clk), .rst (rst), .scl_i (scl_m), .sda_i (sda_line),
        .sda_pull_o (sda_pull), .sel_pins_i (SEL), .wr_busy_i (wr_busy),
        .cycle_start_o (cyc_start), .mem_addr_o (mem_addr), .mem_wr_o (mem_wr),
        .mem_wdata_o (mem_wdata), .mem_rd_o (mem_rd), .mem_rdata_i (mem_rdata)
    );

    // array model and write-cycle timer
    logic [7:0] arr [int];
    logic [7:0] ref_mem [int];

    function automatic logic [7:0] init_val(logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5C;
    endfunction

    function automatic logic [7:0] ref_rd(logic [14:0] a);
        if (ref_mem.exists(int'(a))) return ref_mem[int'(a)];
        return init_val(a);
    endfunction

    always @(posedge clk) begin
        if (mem_wr) arr[int'(mem_addr)] = mem_wdata;
        if (mem_rd) mem_rdata <= arr.exists(int'(mem_addr)) ? arr[int'(mem_addr)] : init_val(mem_addr);
    end

    always @(posedge clk) begin
        if (rst) busy_cnt <= 0;
        else if (cyc_start) begin busy_cnt <= BUSY_CYC; cs_count <= cs_count + 1; end
        else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // scoreboard for array writes
    typedef struct { int addr; int data; } wr_item_t;
    wr_item_t exp_wr_q[$];
    logic [7:0] exp_rd_q[$];

    always @(negedge clk) begin
        if (!rst && mem_wr) begin
            if (exp_wr_q.size() == 0) begin
                chk(0, "R3", "unexpected array write addr", int'(mem_addr), -1);
            end else begin
                wr_item_t it;
                it = exp_wr_q.pop_front();
                chk(int'(mem_addr) == it.addr, "R4", "write address", int'(mem_addr), it.addr);
                chk(int'(mem_wdata) == it.data, "R3", "write data", int'(mem_wdata), it.data);
            end
        end
    end

    // bus master
    task automatic tick(int n); repeat (n) @(negedge clk); endtask
    task automatic bus_start();
        sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
    endtask
    task automatic bus_stop();
        sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
    endtask
    task automatic put_bit(logic b);
        sda_m = b; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
    endtask
    task automatic get_bit(output logic b);
        sda_m = 1; tick(Q); scl_m = 1; tick(Q); b = sda_line; tick(Q); scl_m = 0; tick(Q);
    endtask
    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask
    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        put_bit(~give_ack);
    endtask

    task automatic send_ok(input logic [7:0] v, input string req);
        logic a;
        send_byte(v, a);
        chk(a == 1'b1, req, "acknowledge", int'(a), 1);
    endtask
    task automatic send_refused(input logic [7:0] v, input string req);
        logic a;
        send_byte(v, a);
        chk(a == 1'b0, req, "no acknowledge", int'(a), 0);
    endtask

    // driver: pushes expected read, monitor compares as the byte arrives
    task automatic read_cmp(input logic [14:0] a, input logic give_ack, input string req);
        logic [7:0] v, e;
        exp_rd_q.push_back(ref_rd(a));
        recv_byte(give_ack, v);
        e = exp_rd_q.pop_front();
        chk(v == e, req, "read byte", int'(v), int'(e));
    endtask

    task automatic load_addr(input logic [7:0] hi, input logic [7:0] lo, input string req);
        bus_start();
        send_ok(DEV_W, req);
        send_ok(hi, req);
        send_ok(lo, req);
    endtask

    task automatic write_byte_exp(input logic [14:0] a, input logic [7:0] d, input string req);
        exp_wr_q.push_back('{int'(a), int'(d)});
        ref_mem[int'(a)] = d;
        send_ok(d, req);
    endtask

    task automatic wait_idle();
        while (wr_busy) tick(1);
        tick(4);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual 0x1 expected 0x0");
        finish_run();
    end

    initial begin
        logic [14:0] ctr;
        logic b;
        tick(6);
        rst = 0;
        tick(6);
        // R1 reset state
        chk(sda_pull == 0, "R1", "pull after reset", int'(sda_pull), 0);
        chk(mem_wr == 0 && mem_rd == 0, "R1", "strobes after reset", int'(mem_wr | mem_rd), 0);
        chk(cs_count == 0, "R1", "cycle pulses after reset", cs_count, 0);
        // R1 clocking without a start is ignored
        for (int i = 0; i < 9; i++) begin get_bit(b); chk(b == 1, "R1", "line idle w/o start", int'(b), 1); end

        // byte write, bit 7 of high address ignored (R3, R2, R5)
        load_addr(8'h92, 8'h34, "R2");
        write_byte_exp(15'h1234, 8'h5A, "R3");
        bus_stop();
        tick(4);
        chk(cs_count == 1, "R5", "cycle pulses after write", cs_count, 1);
        chk(wr_busy == 1, "R5", "timer started", int'(wr_busy), 1);
        ctr = 15'h1235;

        // acknowledge polling (R6)
        bus_start();
        send_refused(DEV_W, "R6");
        bus_stop();
        wait_idle();
        bus_start();
        send_ok(DEV_W, "R6");
        bus_stop();
        tick(4);
        chk(cs_count == 1, "R5", "no pulse without data", cs_count, 1);

        // random read (R8)
        load_addr(8'h12, 8'h34, "R8");
        bus_start();
        send_ok(DEV_R, "R8");
        read_cmp(15'h1234, 1'b0, "R8");
        bus_stop();
        tick(4);
        chk(cs_count == 1, "R5", "dummy write gives no pulse", cs_count, 1);

        // current-address reads (R7)
        for (int k = 0; k < 2; k++) begin
            bus_start();
            send_ok(DEV_R, "R7");
            read_cmp(ctr, 1'b0, "R7");
            bus_stop();
            ctr = ctr + 1;
        end

        // page write crossing page end (R4)
        load_addr(8'h01, 8'h3E, "R4");
        write_byte_exp(15'h013E, 8'h11, "R4");
        write_byte_exp(15'h013F, 8'h12, "R4");
        write_byte_exp(15'h0100, 8'h13, "R4");
        write_byte_exp(15'h0101, 8'h14, "R4");
        bus_stop();
        wait_idle();
        chk(cs_count == 2, "R5", "one pulse per page write", cs_count, 2);
        bus_start();
        send_ok(DEV_R, "R7");
        read_cmp(15'h0102, 1'b0, "R4");
        bus_stop();

        // sequential read across page border (R9)
        load_addr(8'h01, 8'h3E, "R9");
        bus_start();
        send_ok(DEV_R, "R9");
        read_cmp(15'h013E, 1'b1, "R9");
        read_cmp(15'h013F, 1'b1, "R9");
        read_cmp(15'h0140, 1'b1, "R9");
        read_cmp(15'h0141, 1'b0, "R9");
        bus_stop();

        // wrap at array end (R9), then released line after no-acknowledge (R10)
        load_addr(8'h7F, 8'hFE, "R9");
        bus_start();
        send_ok(DEV_R, "R9");
        read_cmp(15'h7FFE, 1'b1, "R9");
        read_cmp(15'h7FFF, 1'b1, "R9");
        read_cmp(15'h0000, 1'b0, "R9");
        for (int i = 0; i < 9; i++) begin get_bit(b); chk(b == 1, "R10", "line released after no-ack", int'(b), 1); end
        bus_stop();
        ctr = 15'h0001;
        bus_start();
        send_ok(DEV_R, "R9");
        read_cmp(ctr, 1'b0, "R9");
        bus_stop();
        ctr = ctr + 1;

        // mismatched select bytes (R2)
        bus_start();
        send_refused({4'b1010, 3'b001, 1'b0}, "R2");
        send_refused(8'h00, "R2");
        send_refused(8'h00, "R2");
        send_refused(8'h77, "R2");
        bus_stop();
        bus_start();
        send_refused({4'b1011, SEL, 1'b0}, "R2");
        bus_stop();
        tick(4);
        chk(cs_count == 2, "R2", "no pulse after refused select", cs_count, 2);
        bus_start();
        send_ok(DEV_R, "R2");
        read_cmp(ctr, 1'b0, "R2");
        bus_stop();
        ctr = ctr + 1;

        // abort by repeated start mid-byte (R11)
        bus_start();
        send_ok(DEV_W, "R11");
        for (int i = 0; i < 4; i++) put_bit(1'b0);
        bus_start();
        send_ok(DEV_R, "R11");
        read_cmp(ctr, 1'b0, "R11");
        bus_stop();
        ctr = ctr + 1;

        // abort by stop mid-byte (R11)
        bus_start();
        send_ok(DEV_W, "R11");
        for (int i = 0; i < 3; i++) put_bit(1'b1);
        bus_stop();
        bus_start();
        send_ok(DEV_R, "R11");
        read_cmp(ctr, 1'b0, "R11");
        bus_stop();
        tick(8);
        chk(cs_count == 2, "R11", "aborted write gives no pulse", cs_count, 2);
        chk(exp_wr_q.size() == 0, "R3", "pending expected writes", exp_wr_q.size(), 0);
        finish_run();
    end
endmodule